// File: doc/BRIEF.md
# Multi-Source Timer Counter Channel

A single timer/counter channel that advances a 32-bit count on enables taken from one of eight sources: four taps of a free-running divider of the system clock (by 2, 8, 32 and 128), a slow-clock enable supplied from outside, or a rising edge on one of three external clock inputs. External inputs are asynchronous. They pass through a two-flop synchroniser and an edge detector before they are counted. When the overflow output of one channel drives an external input of another, two channels form a longer counter.

The count runs up or down. A separate 2-bit Gray-code output steps one phase per count in the selected direction, so a stepper-motor driver can take its phases straight from the pins. Software starts and stops the channel through a small write port. A block-level start pulse restarts several channels on the same clock edge. A wrap in either direction sets a sticky overflow flag, which a status-read strobe clears and which drives the interrupt when it is enabled.

Top module: `tmr_channel`

## Requirements
- R1: After reset, the count is 0, the channel is stopped, the overflow flag and interrupt are low, and the Gray output is 00.
- R2: The 3-bit clock-select field (address 1, bits 2:0) chooses the count source. Values 0..3 count once every 2, 8, 32 and 128 clocks, and the divider restarts at each start, so the count equals floor(m/N) m clocks after the start edge. Value 4 counts on each clock where slow_en_i is high.
- R3: Select values 5..7 count rising edges of ext_clk_i[0..2]. A rising edge is counted on the third clock edge after it is presented. Falling edges and edges on unselected inputs are ignored.
- R4: Mode bit 3 at address 1 selects the direction: 0 counts up, 1 counts down.
- R5: When mode bit 4 at address 1 is set, the Gray output steps once per count through 00,01,11,10 going up, and in the reverse order going down. It returns to 00 on start and holds while bit 4 is clear.
- R6: A count from all ones upward, or from zero downward, wraps the counter and sets the overflow flag.
- R7: A status-read strobe clears the overflow flag. A wrap in the same cycle leaves the flag set.
- R8: The interrupt is high exactly while the overflow flag is set and bit 0 at address 2 is set.
- R9: A write of bit 1 at address 0 stops the channel. While stopped, the count holds its value.
- R10: Either a write of bit 0 at address 0 or a pulse on block_start_i clears the count to 0 and runs the channel. Overflow state is kept. When start and stop arrive together, start wins.
- R11: Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_en_i | input | 1 | Slow-clock enable, one clock wide per slow tick |
| ext_clk_i | input | 3 | Asynchronous external clock inputs |
| block_start_i | input | 1 | Block-wide synchronous start pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 command, 1 mode, 2 interrupt enable) |
| wr_data_i | input | 32 | Register write data |
| stat_rd_i | input | 1 | Status read strobe, clears overflow |
| cnt_o | output | 32 | Counter value |
| run_o | output | 1 | Channel running |
| ovf_o | output | 1 | Sticky overflow flag |
| gray_o | output | 2 | Gray-code phase pair |
| irq_o | output | 1 | Interrupt |

## Verification
The upward wrap is the hardest case to reach from the ports. A start always clears the count, and counting up to all ones takes 2^32 enables. The stimulus gets there by a different route: it selects the slow-clock source, counts down once from zero so the counter wraps to all ones, rewrites the direction bit without a restart, and gives one more slow enable. The set-wins case is reached in a similar way. A slow enable that causes a wrap is placed in the same cycle as the status-read strobe.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    CS_DIV2   = 3'd0,
    CS_DIV8   = 3'd1,
    CS_DIV32  = 3'd2,
    CS_DIV128 = 3'd3,
    CS_SLOW   = 3'd4,
    CS_EXT0   = 3'd5,
    CS_EXT1   = 3'd6,
    CS_EXT2   = 3'd7
  } clk_sel_e;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_IER  = 2'd2;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_STOP_BIT  = 1;
  localparam int MODE_DOWN_BIT = 3;
  localparam int MODE_GRAY_BIT = 4;

  localparam int N_TAPS = 4;
  localparam int N_EXT  = 3;

  function automatic logic [1:0] gray_to_bin(input logic [1:0] g);
    return {g[1], g[1] ^ g[0]};
  endfunction

  function automatic logic [1:0] bin_to_gray(input logic [1:0] b);
    return {b[1], b[1] ^ b[0]};
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int N_TAPS  = 4,
  parameter int TAP_LOG2_0 = 1,
  parameter int TAP_LOG2_1 = 3,
  parameter int TAP_LOG2_2 = 5,
  parameter int TAP_LOG2_3 = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  output logic [N_TAPS-1:0] tick_o
);
  localparam int PRE_W = TAP_LOG2_3;
  localparam int TAP_LOG2 [4] = '{TAP_LOG2_0, TAP_LOG2_1, TAP_LOG2_2, TAP_LOG2_3};

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end

  // tap i fires once every 2**TAP_LOG2[i] clocks
  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    assign tick_o[i] = &pre_q[TAP_LOG2[i]-1:0];
  end
endmodule

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int N_EXT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] ext_i,
  output logic [N_EXT-1:0] rise_o
);
  for (genvar i = 0; i < N_EXT; i++) begin : g_ch
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= ext_i[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign rise_o[i] = sync_q & ~prev_q;
  end
endmodule

// File: rtl/tmr_gray_step.sv
module tmr_gray_step
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       step_i,
  input  logic       down_i,
  output logic [1:0] gray_o
);
  logic [1:0] gray_q, bin_cur, bin_nxt;

  always_comb begin
    bin_cur = gray_to_bin(gray_q);
    bin_nxt = down_i ? bin_cur - 2'd1 : bin_cur + 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gray_q <= 2'b00;
    else if (clr_i)  gray_q <= 2'b00;
    else if (step_i) gray_q <= bin_to_gray(bin_nxt);
  end

  assign gray_o = gray_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         down_i,
  input  logic         clr_ovf_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         ovf_q;
  logic         wrap;

  assign wrap = en_i & ~clr_i & (down_i ? (cnt_q == '0) : (&cnt_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= down_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
  end

  // set dominates clear-on-read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (wrap)      ovf_q <= 1'b1;
    else if (clr_ovf_i) ovf_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_en_i,
  input  logic [2:0]        ext_clk_i,
  input  logic              block_start_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              stat_rd_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              run_o,
  output logic              ovf_o,
  output logic [1:0]        gray_o,
  output logic              irq_o
);
  clk_sel_e          clk_sel_q;
  logic              down_q, gray_en_q, ier_q, run_q;
  logic              cmd_wr, mode_wr, ier_wr;
  logic              start, stop;
  logic [N_TAPS-1:0] pre_tick;
  logic [N_EXT-1:0]  ext_rise;
  logic              src_tick, cnt_en;

  assign cmd_wr  = wr_en_i && (wr_addr_i == ADDR_CMD);
  assign mode_wr = wr_en_i && (wr_addr_i == ADDR_MODE);
  assign ier_wr  = wr_en_i && (wr_addr_i == ADDR_IER);
  assign start   = block_start_i | (cmd_wr & wr_data_i[CMD_START_BIT]);
  assign stop    = cmd_wr & wr_data_i[CMD_STOP_BIT] & ~start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sel_q <= CS_DIV2;
      down_q    <= 1'b0;
      gray_en_q <= 1'b0;
    end else if (mode_wr) begin
      clk_sel_q <= clk_sel_e'(wr_data_i[2:0]);
      down_q    <= wr_data_i[MODE_DOWN_BIT];
      gray_en_q <= wr_data_i[MODE_GRAY_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ier_q <= 1'b0;
    else if (ier_wr) ier_q <= wr_data_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 1'b0;
    else if (start)  run_q <= 1'b1;
    else if (stop)   run_q <= 1'b0;
  end

  tmr_prescaler #(.N_TAPS(N_TAPS)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .tick_o (pre_tick)
  );

  tmr_ext_sync #(.N_EXT(N_EXT)) u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (ext_clk_i),
    .rise_o (ext_rise)
  );

  always_comb begin
    unique case (clk_sel_q)
      CS_DIV2:   src_tick = pre_tick[0];
      CS_DIV8:   src_tick = pre_tick[1];
      CS_DIV32:  src_tick = pre_tick[2];
      CS_DIV128: src_tick = pre_tick[3];
      CS_SLOW:   src_tick = slow_en_i;
      CS_EXT0:   src_tick = ext_rise[0];
      CS_EXT1:   src_tick = ext_rise[1];
      CS_EXT2:   src_tick = ext_rise[2];
      default:   src_tick = 1'b0;
    endcase
  end

  assign cnt_en = run_q & src_tick & ~start;

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start),
    .en_i      (cnt_en),
    .down_i    (down_q),
    .clr_ovf_i (stat_rd_i),
    .cnt_o     (cnt_o),
    .ovf_o     (ovf_o)
  );

  tmr_gray_step u_gray (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .step_i (cnt_en & gray_en_q),
    .down_i (down_q),
    .gray_o (gray_o)
  );

  assign run_o = run_q;
  assign irq_o = ovf_o & ier_q;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              block_start_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              run_o,
  input logic              ovf_o,
  input logic [1:0]        gray_o,
  input logic              irq_o
);
  logic start_now;
  assign start_now = block_start_i |
                     (wr_en_i && wr_addr_i == ADDR_CMD && wr_data_i[CMD_START_BIT]);

  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o && !start_now |=> $stable(cnt_o)); // R9

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_now |=> (cnt_o == '0) && run_o); // R10

  AST_GRAY_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_now |=> $countones(gray_o ^ $past(gray_o)) <= 1); // R5

  AST_IRQ_NEEDS_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_o |-> !irq_o); // R8

  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && !start_now |=> (cnt_o == $past(cnt_o)) ||
                            (cnt_o == $past(cnt_o) + 1'b1) ||
                            (cnt_o == $past(cnt_o) - 1'b1)); // R4

  AST_OVF_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> (($past(cnt_o) == '1) && (cnt_o == '0)) ||
                     (($past(cnt_o) == '0) && (cnt_o == '1))); // R6
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .block_start_i (block_start_i),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .wr_data_i     (wr_data_i),
  .cnt_o         (cnt_o),
  .run_o         (run_o),
  .ovf_o         (ovf_o),
  .gray_o        (gray_o),
  .irq_o         (irq_o)
);

// File: tb/tmr_channel_tb_top.sv
module tmr_channel_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slow_en_i = 1'b0;
  logic [2:0]  ext_clk_i = '0;
  logic        block_start_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        stat_rd_i = 1'b0;
  logic [31:0] cnt_o;
  logic        run_o, ovf_o, irq_o;
  logic [1:0]  gray_o;

  int n_checks = 0;
  int n_err = 0;

  always #4 clk_i = ~clk_i;

  tmr_channel dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_en_i(slow_en_i), .ext_clk_i(ext_clk_i),
    .block_start_i(block_start_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .stat_rd_i(stat_rd_i), .cnt_o(cnt_o), .run_o(run_o),
    .ovf_o(ovf_o), .gray_o(gray_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic slow_pulse();
    slow_en_i = 1'b1;
    @(negedge clk_i);
    slow_en_i = 1'b0;
  endtask

  task automatic status_read();
    stat_rd_i = 1'b1;
    @(negedge clk_i);
    stat_rd_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cnt", cnt_o, 0);
    chk("R1 run", {31'b0, run_o}, 0);
    chk("R1 ovf", {31'b0, ovf_o}, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 gray", {30'b0, gray_o}, 0);
  endtask

  task automatic t_div();
    wr(2'd1, 32'd0); wr(2'd0, 32'h1); wait_cyc(10);
    chk("R2 div2", cnt_o, 5);
    wr(2'd1, 32'd1); wr(2'd0, 32'h1); wait_cyc(43);
    chk("R2 div8", cnt_o, 5);
    wr(2'd1, 32'd2); wr(2'd0, 32'h1); wait_cyc(64);
    chk("R2 div32", cnt_o, 2);
    wr(2'd1, 32'd3); wr(2'd0, 32'h1); wait_cyc(383);
    chk("R2 div128", cnt_o, 2);
  endtask

  task automatic t_slow();
    wr(2'd1, 32'd4); wr(2'd0, 32'h1);
    wait_cyc(6);
    chk("R2 slow idle", cnt_o, 0);
    for (int i = 0; i < 5; i++) begin slow_pulse(); wait_cyc(1); end
    chk("R2 slow count", cnt_o, 5);
  endtask

  task automatic t_ext();
    wr(2'd1, 32'd5); wr(2'd0, 32'h1);
    ext_clk_i[1] = 1'b1; wait_cyc(4); ext_clk_i[1] = 1'b0; wait_cyc(4);
    chk("R3 other input ignored", cnt_o, 0);
    ext_clk_i[0] = 1'b1;
    wait_cyc(2);
    chk("R3 latency before", cnt_o, 0);
    wait_cyc(1);
    chk("R3 latency at third edge", cnt_o, 1);
    ext_clk_i[0] = 1'b0; wait_cyc(5);
    chk("R3 falling ignored", cnt_o, 1);
    for (int i = 0; i < 3; i++) begin
      ext_clk_i[0] = 1'b1; wait_cyc(3); ext_clk_i[0] = 1'b0; wait_cyc(3);
    end
    chk("R3 edge count", cnt_o, 4);
  endtask

  task automatic t_wrap();
    wr(2'd2, 32'd0);
    wr(2'd1, 32'h0000_000C); // slow, down
    wr(2'd0, 32'h1);
    slow_pulse();
    chk("R4 R6 down wrap", cnt_o, 32'hFFFF_FFFF);
    chk("R6 ovf down", {31'b0, ovf_o}, 1);
    chk("R8 irq masked", {31'b0, irq_o}, 0);
    wr(2'd2, 32'd1);
    chk("R8 irq enabled", {31'b0, irq_o}, 1);
    status_read();
    chk("R7 cleared", {31'b0, ovf_o}, 0);
    chk("R8 irq drops", {31'b0, irq_o}, 0);
    wr(2'd1, 32'h0000_0004); // slow, up, no restart
    chk("R4 value kept", cnt_o, 32'hFFFF_FFFF);
    slow_en_i = 1'b1; stat_rd_i = 1'b1;
    @(negedge clk_i);
    slow_en_i = 1'b0; stat_rd_i = 1'b0;
    chk("R6 up wrap", cnt_o, 0);
    chk("R7 set wins", {31'b0, ovf_o}, 1);
    slow_pulse();
    chk("R4 up step", cnt_o, 1);
    status_read();
    wr(2'd2, 32'd0);
  endtask

  task automatic t_stop_start();
    wr(2'd1, 32'd0); wr(2'd0, 32'h1); wait_cyc(8);
    wr(2'd0, 32'h2);
    chk("R9 stopped", {31'b0, run_o}, 0);
    begin
      logic [31:0] held;
      held = cnt_o;
      wait_cyc(12);
      chk("R9 hold", cnt_o, held);
      chk("R9 hold nonzero", {31'b0, (held != 0)}, 1);
    end
    wr(2'd3, 32'hFFFF_FFFF);
    wait_cyc(4);
    chk("R11 addr3 run", {31'b0, run_o}, 0);
    wr(2'd1, 32'd4); wr(2'd0, 32'h1); slow_pulse();
    chk("R11 mode kept", cnt_o, 1);
    wr(2'd0, 32'h2);
    block_start_i = 1'b1; @(negedge clk_i); block_start_i = 1'b0;
    chk("R10 block start clears", cnt_o, 0);
    chk("R10 block start runs", {31'b0, run_o}, 1);
    wr(2'd0, 32'h2);
    wr(2'd0, 32'h3);
    chk("R10 start beats stop", {31'b0, run_o}, 1);
  endtask

  task automatic t_gray();
    logic [1:0] up_seq [4] = '{2'b01, 2'b11, 2'b10, 2'b00};
    logic [1:0] dn_seq [4] = '{2'b10, 2'b11, 2'b01, 2'b00};
    wr(2'd1, 32'h0000_0004); wr(2'd0, 32'h1);
    slow_pulse();
    chk("R5 gray disabled holds", {30'b0, gray_o}, 0);
    wr(2'd1, 32'h0000_0014); wr(2'd0, 32'h1);
    for (int i = 0; i < 4; i++) begin
      slow_pulse();
      chk("R5 gray up", {30'b0, gray_o}, {30'b0, up_seq[i]});
    end
    slow_pulse();
    wr(2'd0, 32'h1);
    chk("R5 gray start clears", {30'b0, gray_o}, 0);
    wr(2'd1, 32'h0000_001C);
    for (int i = 0; i < 4; i++) begin
      slow_pulse();
      chk("R5 gray down", {30'b0, gray_o}, {30'b0, dn_seq[i]});
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    t_reset();
    rst_ni = 1'b1;
    wait_cyc(2);
    t_reset();
    t_div();
    t_slow();
    t_ext();
    t_wrap();
    t_stop_start();
    t_gray();
    finish_run();
  end
endmodule